// File: doc/BRIEF.md
# Toggling 0-1-1 Serial Pattern Detector

This block watches a single serial bit that is sampled on every rising clock edge. It looks for the three-bit pattern 0, then 1, then 1. It does not raise a one-cycle match pulse. Instead, each time the pattern completes, it inverts a held output level. The level then stays put until the pattern completes again. A downstream consumer can therefore tell whether an odd or an even number of completions has occurred since reset, just by reading the level.

The machine is a Moore machine with six states stored in three flip-flops. Two flip-flops hold how much of the pattern has been seen: nothing useful, a 0, or a 0 followed by a 1. The third flip-flop holds the output phase and drives the output pin directly. Reset is synchronous and active low. Reset clears the progress and forces the level to 0.

Top module: `seq_toggle_det`

## Requirements
- R1: While `rst_n` is low at a rising edge, the machine returns to the no-progress state with `level_out` = 0. After release, a following 1,1 does not change `level_out`.
- R2: The first completion of 0,1,1 after reset drives `level_out` from 0 to 1. The change is visible in the cycle after the edge that samples the final 1.
- R3: Each further completion inverts `level_out` again, so the second completion returns it to 0.
- R4: On any edge that does not complete the pattern, `level_out` keeps its previous value.
- R5: A sampled 0 always moves the progress to the saw-0 state, whatever came before. For example, 0,0,0,1,1 completes the pattern once.
- R6: A 1 sampled with no progress leaves the progress at none. A completion also returns the progress to none, so 0,1,1,1 gives exactly one toggle.
- R7: A pattern may start inside a failed attempt. For example, 0,1,0,1,1 completes exactly once, on the last bit.
- R8: The progress field only ever holds its three legal codes: none = 0, saw-0 = 1, saw-01 = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; `din` is sampled on every edge |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Serial input bit |
| level_out | output | 1 | Held level, inverted on each completion of 0,1,1 |

## Verification
Several rules are checked by the bound assertions on every clock cycle:
- the output toggles after the edge whenever the saw-01 progress meets a sampled 1, and is stable otherwise;
- a sampled 0 always leads to the saw-0 progress;
- a 1 with no progress stays at none;
- the progress code stays legal;
- the cycle after a reset edge shows the cleared state.

Some behaviour only shows up in the bench's scenarios against its reference model. This covers the parity of the level across many completions, restarts inside a failed attempt, repeated trailing ones, and a reset in the middle of a partial match that must not let a later 1,1 complete the pattern.

// File: rtl/seq_toggle_det_pkg.sv
// Package: shared encodings for the toggling 0-1-1 detector.
// Assumes: progress codes are consumed by both the progress tracker and
// the checker, so the numeric values below are part of the contract.
package seq_toggle_det_pkg;

    // Width of the match-progress field.
    localparam int PROG_W = 2;

    // Length of the pattern being tracked (0,1,1).
    localparam int PATTERN_LEN = 3;

    // Match progress: how much of 0,1,1 has been seen so far.
    typedef enum logic [PROG_W-1:0] {
        PROG_NONE  = 2'd0,
        PROG_SAW0  = 2'd1,
        PROG_SAW01 = 2'd2
    } prog_e;

    // Level applied to the output phase on reset.
    localparam logic LEVEL_RESET = 1'b0;

endpackage

// File: rtl/seq_toggle_progress.sv
// Module: seq_toggle_progress
// Tracks how much of the pattern 0,1,1 has been received and flags the
// edge on which the pattern completes.
// Assumes: din is synchronous to clk; rst_n is synchronous, active low.
module seq_toggle_progress
    import seq_toggle_det_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  din,
    output prog_e prog_q,
    output logic  complete
);

    prog_e prog_d;

    // Next-progress decode and completion flag for the current bit.
    always_comb begin
        prog_d   = prog_q;
        complete = 1'b0;
        if (!din) begin
            prog_d = PROG_SAW0;
        end else begin
            unique case (prog_q)
                PROG_NONE:  prog_d = PROG_NONE;
                PROG_SAW0:  prog_d = PROG_SAW01;
                PROG_SAW01: begin
                    prog_d   = PROG_NONE;
                    complete = 1'b1;
                end
                default:    prog_d = PROG_NONE;
            endcase
        end
    end

    // Progress register with synchronous reset to no progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q <= PROG_NONE;
        end else begin
            prog_q <= prog_d;
        end
    end

endmodule

// File: rtl/seq_toggle_phase.sv
// Module: seq_toggle_phase
// Holds the output phase bit and inverts it when a completion is flagged.
// Assumes: complete is a single-cycle qualifier from the progress tracker.
module seq_toggle_phase
    import seq_toggle_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic complete,
    output logic level_q
);

    // Phase flip-flop, toggled on completion, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= LEVEL_RESET;
        end else if (complete) begin
            level_q <= ~level_q;
        end
    end

endmodule

// File: rtl/seq_toggle_det.sv
// Module: seq_toggle_det (top)
// Moore detector for the serial pattern 0,1,1 whose output is a held
// level that flips on every completion. Three flip-flops in total: two
// for progress, one for the output phase, which drives the pin directly.
// Assumes: one input bit per clock; synchronous active-low reset.
module seq_toggle_det
    import seq_toggle_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_out
);

    prog_e prog_q;
    logic  complete;
    logic  level_q;

    // Pattern progress tracker.
    seq_toggle_progress u_progress (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .prog_q   (prog_q),
        .complete (complete)
    );

    // Output phase register.
    seq_toggle_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .complete (complete),
        .level_q  (level_q)
    );

    // Output straight from the phase flip-flop.
    assign level_out = level_q;

endmodule

// File: rtl/seq_toggle_det_chk.sv
// Module: seq_toggle_det_chk
// Assertion checker bound into seq_toggle_det. It relates the progress
// register to the output phase register across clock edges.
// Assumes: the bench holds rst_n low for at least two edges at start.
module seq_toggle_det_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       din,
    input logic       level_out,
    input logic [1:0] prog
);

    logic rst_prev_low_q = 1'b0;

    // Check the cleared state one edge after a reset edge.
    always_ff @(posedge clk) begin
        if (rst_prev_low_q) begin
            AST_RESET_CLEARS: assert (level_out == 1'b0 && prog == 2'd0) else $error("reset state wrong"); // R1
        end
        rst_prev_low_q <= !rst_n;
    end

    AST_MATCH_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n) (prog == 2'd2 && din) |=> (level_out != $past(level_out))); // R3

    AST_HOLD_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n) !(prog == 2'd2 && din) |=> $stable(level_out)); // R4

    AST_ZERO_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) !din |=> (prog == 2'd1)); // R5

    AST_ONE_FROM_NONE: assert property (@(posedge clk) disable iff (!rst_n) (prog == 2'd0 && din) |=> (prog == 2'd0)); // R6

    AST_PROG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) prog != 2'd3); // R8

endmodule

bind seq_toggle_det seq_toggle_det_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .level_out (level_out),
    .prog      (prog_q)
);

// File: tb/seq_toggle_det_bench.sv
// Bench for seq_toggle_det: directed corner cases plus seeded random bits,
// compared against a reference model of the requirements.
module seq_toggle_det_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_BITS  = 3000;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic level_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state: 0 none, 1 saw 0, 2 saw 01.
    int m_prog = 0;
    bit m_level = 1'b0;

    seq_toggle_det u_seq_toggle_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .level_out (level_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference step for one sampled bit; returns 1 on completion.
    function automatic bit model_step(input bit b);
        bit hit = 1'b0;
        if (!b) begin
            m_prog = 1;
        end else begin
            case (m_prog)
                0: m_prog = 0;
                1: m_prog = 2;
                default: begin
                    m_prog  = 0;
                    m_level = ~m_level;
                    hit     = 1'b1;
                end
            endcase
        end
        return hit;
    endfunction

    task automatic check(input logic exp, input string req);
        checks++;
        if (level_out !== exp) begin
            errors++;
            $display("FAIL %s: level_out=%b expected=%b", req, level_out, exp);
        end
    endtask

    // Drive one bit from a negedge, let one edge pass, check at next negedge.
    task automatic step(input bit b, input string req);
        bit hit;
        din = b;
        @(posedge clk);
        hit = model_step(b);
        @(negedge clk);
        if (req == "") check(m_level, hit ? "R3" : "R4");
        else           check(m_level, req);
    endtask

    task automatic do_reset(input int cycles);
        rst_n = 1'b0;
        din   = 1'b0;
        repeat (cycles) @(posedge clk);
        m_prog  = 0;
        m_level = 1'b0;
        @(negedge clk);
        check(1'b0, "R1");
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset(3);

        // R2: first completion sets the level.
        step(0, "R2"); step(1, "R2"); step(1, "R2");
        // R6: trailing 1 after completion does nothing.
        step(1, "R6");
        // R3: second completion clears it.
        step(0, "R3"); step(1, "R3"); step(1, "R3");
        // R6: ones with no progress hold.
        step(1, "R6"); step(1, "R6"); step(1, "R6");
        // R5: repeated zeros then 1,1.
        step(0, "R5"); step(0, "R5"); step(0, "R5"); step(1, "R5"); step(1, "R5");
        // R7: restart inside a failed attempt.
        step(0, "R7"); step(1, "R7"); step(0, "R7"); step(1, "R7"); step(1, "R7");
        // R6: 0,1,1,1,1 toggles once.
        step(0, "R6"); step(1, "R6"); step(1, "R6"); step(1, "R6"); step(1, "R6");
        // R1: reset in the middle of a saw-01 state; later 1,1 must not toggle.
        step(0, "R4"); step(1, "R4");
        do_reset(1);
        step(1, "R1"); step(1, "R1");

        // Random traffic checked against the model.
        for (int i = 0; i < RAND_BITS; i++) begin
            step(bit'($urandom % 2), "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: level_out=%b expected=finished run", level_out);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule